// File: doc/BRIEF.md
# Capacitive touch scan wakeup controller

This block runs periodic measurement scans over a bank of capacitive touch channels and decides whether a scan result should wake the system. A scan starts either from an internal idle timer or from a software start pulse. The configuration input `cfg_force_sw` selects which of the two is used. During a scan the block visits the pads of the working set one at a time. For each pad it raises the power-up output, waits a programmed settling time, then raises the measurement-start output. While start is high it counts pulses from the pad's charge oscillator for a programmed window.

Each count is stored per pad and compared with that pad's 16-bit threshold. A configuration bit sets the direction of the comparison. The resulting touched bitmap is OR-reduced over two pad-set masks, and those two results drive a one-cycle wakeup pulse. Configuration arrives as plain inputs from a register file outside this block. The oscillator is external, and a stub stands in for it in the bench. For bring-up, the power-up and start outputs can be handed over to direct register values.

Top module: `touch_wake_ctrl`

## Requirements
- R1: After synchronous reset, `touched`, `scan_done`, `wake_irq`, `touch_xpd`, `touch_start` and every stored count are zero, and the block waits idle.
- R2: With `cfg_force_sw`=1, a one-cycle `sw_start` pulse sampled while idle launches a scan, so `touch_xpd` is high in the cycle after that clock edge.
- R3: With `cfg_force_sw`=0, `sw_start` has no effect: no scan starts until the idle timer expires.
- R4: With `cfg_force_sw`=0, scans repeat on their own. The block stays idle for `sleep_cycles` cycles (minimum 1) after each scan, so one pad gives a period of `xpd_wait`+`meas_window`+1+`sleep_cycles` cycles between rising edges of `touch_xpd`.
- R5: For each measured pad, `touch_xpd` is high for `xpd_wait`+`meas_window` cycles (each value minimum 1). `touch_start` is high only in the last `meas_window` of those cycles.
- R6: Pads are measured in ascending index order. Only pads whose bit i of `work_set` is 1 are measured, and `pad_sel` shows the pad being measured.
- R7: A measured pad's count is the number of cycles with `osc_edge` high while its `touch_start` is high. The count saturates at all ones and is presented on `meas_count[16i+15:16i]`. Pads that are not measured keep their previous count.
- R8: With `cmp_above`=1, pad i is touched when its count is strictly greater than `thresh[16i+15:16i]`. An equal count is not touched.
- R9: With `cmp_above`=0, pad i is touched when its count is strictly less than its threshold.
- R10: With `single_set`=1, the block pulses `wake_irq` for one cycle at scan end if any pad in `set1_mask` is touched.
- R11: With `single_set`=0, `wake_irq` needs at least one touched pad in `set1_mask` and at least one touched pad in `set2_mask`.
- R12: At scan end, `scan_done` goes to 1 and `touched` is updated, with bit i forced to 0 for pads outside `work_set`. `scan_done` returns to 0 at the next launch.
- R13: A `clr_touched` pulse clears `touched` to zero in the next cycle, unless a scan is finishing in that same cycle.
- R14: With `fsm_en`=0, `touch_xpd` and `touch_start` follow `reg_xpd` and `reg_start`, even while a scan runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_force_sw | input | 1 | 1: software launches scans; 0: the idle timer launches them |
| sw_start | input | 1 | Software launch pulse |
| sleep_cycles | input | 16 | Idle cycles between timer-launched scans |
| xpd_wait | input | 8 | Settling cycles from power-up to start |
| meas_window | input | 16 | Measurement window in cycles |
| work_set | input | 10 | Pads to measure, bit i = pad i |
| set1_mask | input | 10 | Pad set 1 |
| set2_mask | input | 10 | Pad set 2 |
| single_set | input | 1 | 1: set 1 alone wakes; 0: both sets needed |
| cmp_above | input | 1 | Comparison direction |
| thresh | input | 160 | Per-pad thresholds, 16 bits each |
| fsm_en | input | 1 | 1: scan sequencer drives the pad controls |
| reg_xpd | input | 1 | Direct power-up value when fsm_en=0 |
| reg_start | input | 1 | Direct start value when fsm_en=0 |
| clr_touched | input | 1 | Clear pulse for the touched bitmap |
| osc_edge | input | 1 | Oscillator pulse of the selected pad, one per cycle at most |
| pad_sel | output | 4 | Index of the pad being measured |
| touch_xpd | output | 1 | Pad power-up |
| touch_start | output | 1 | Pad measurement start |
| meas_count | output | 160 | Stored per-pad counts, 16 bits each |
| touched | output | 10 | Touched bitmap of the last scan |
| scan_done | output | 1 | Scan completed flag |
| wake_irq | output | 1 | One-cycle wakeup pulse |

## Verification
The oscillator stub gives each pad its own number of pulses. Some pads get fewer pulses than the window and are counted exactly. One gets more and is clipped by the window. One gets none, and one lands exactly on its threshold. Together these show the difference between strict and inclusive comparison in both directions. A sparse working set (pads 0, 2, 5, 9) shows the ascending skip order and proves that unmeasured pads keep their counts and never show as touched. The wakeup is then tried with four set-mask combinations: set 1 untouched, only set 1 touched in two-set mode, both sets touched, and set 1 alone in single-set mode. The timer period, the ignored software start and the direct-control mode are each measured separately, in cycles at the pins.

// File: rtl/touch_pkg.sv
package touch_pkg;

    // Scan sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_MEAS   = 2'd2,
        ST_FINISH = 2'd3
    } scan_state_e;

    // Evaluation controls carried together to the wake evaluator
    typedef struct packed {
        logic cmp_above;
        logic single_set;
    } eval_mode_t;

    // True when a phase counter value has reached a programmed length
    // (a length of zero behaves as one)
    function automatic logic phase_done(input logic [31:0] ph, input logic [31:0] len);
        return (ph + 32'd1) >= len;
    endfunction

endpackage

// File: rtl/touch_launch_timer.sv
module touch_launch_timer #(
    parameter int SLEEP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [SLEEP_W-1:0] sleep_cycles,
    output logic               expire
);
    import touch_pkg::*;

    logic [SLEEP_W-1:0] tmr_q;

    assign expire = run && phase_done(32'(tmr_q), 32'(sleep_cycles));

    always_ff @(posedge clk) begin
        if (rst || !run || expire) tmr_q <= '0;
        else                       tmr_q <= tmr_q + 1'b1;
    end

endmodule

// File: rtl/touch_pulse_counter.sv
module touch_pulse_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] acc_next
);
    logic [CNT_W-1:0] acc_q;

    always_comb begin
        acc_next = acc_q;
        if (inc && acc_q != '1) acc_next = acc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else            acc_q <= acc_next;
    end

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_q == '1 && inc && !clr) |=> (acc_q == '1));

endmodule

// File: rtl/touch_wake_eval.sv
module touch_wake_eval #(
    parameter int NPADS = 10,
    parameter int CNT_W = 16
) (
    input  logic [NPADS-1:0][CNT_W-1:0] counts,
    input  logic [NPADS-1:0][CNT_W-1:0] thresholds,
    input  logic [NPADS-1:0]            work_set,
    input  logic [NPADS-1:0]            set1_mask,
    input  logic [NPADS-1:0]            set2_mask,
    input  touch_pkg::eval_mode_t       mode,
    output logic [NPADS-1:0]            hit,
    output logic                        wake
);
    genvar g;
    generate
        for (g = 0; g < NPADS; g++) begin : g_cmp
            logic over, under;
            assign over   = counts[g] > thresholds[g];
            assign under  = counts[g] < thresholds[g];
            assign hit[g] = work_set[g] && (mode.cmp_above ? over : under);
        end
    endgenerate

    logic s1_hit, s2_hit;
    assign s1_hit = |(hit & set1_mask);
    assign s2_hit = |(hit & set2_mask);
    assign wake   = s1_hit && (mode.single_set || s2_hit);

endmodule

// File: rtl/touch_wake_ctrl.sv
module touch_wake_ctrl #(
    parameter int NPADS   = 10,
    parameter int CNT_W   = 16,
    parameter int WAIT_W  = 8,
    parameter int WIN_W   = 16,
    parameter int SLEEP_W = 16,
    localparam int IDX_W  = $clog2(NPADS),
    localparam int PH_W   = (WIN_W > WAIT_W) ? WIN_W : WAIT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_force_sw,
    input  logic                   sw_start,
    input  logic [SLEEP_W-1:0]     sleep_cycles,
    input  logic [WAIT_W-1:0]      xpd_wait,
    input  logic [WIN_W-1:0]       meas_window,
    input  logic [NPADS-1:0]       work_set,
    input  logic [NPADS-1:0]       set1_mask,
    input  logic [NPADS-1:0]       set2_mask,
    input  logic                   single_set,
    input  logic                   cmp_above,
    input  logic [NPADS*CNT_W-1:0] thresh,
    input  logic                   fsm_en,
    input  logic                   reg_xpd,
    input  logic                   reg_start,
    input  logic                   clr_touched,
    input  logic                   osc_edge,
    output logic [IDX_W-1:0]       pad_sel,
    output logic                   touch_xpd,
    output logic                   touch_start,
    output logic [NPADS*CNT_W-1:0] meas_count,
    output logic [NPADS-1:0]       touched,
    output logic                   scan_done,
    output logic                   wake_irq
);
    import touch_pkg::*;

    scan_state_e st_q;
    logic [IDX_W-1:0] cur_q;
    logic [PH_W-1:0]  ph_q;
    logic [NPADS-1:0][CNT_W-1:0] cnt_q;
    logic [NPADS-1:0] touched_q;
    logic done_q, wake_q;

    // Idle timer launch source
    logic tmr_expire, launch;
    touch_launch_timer #(.SLEEP_W(SLEEP_W)) u_timer (
        .clk(clk), .rst(rst),
        .run(st_q == ST_IDLE && !cfg_force_sw),
        .sleep_cycles(sleep_cycles),
        .expire(tmr_expire)
    );
    assign launch = cfg_force_sw ? sw_start : tmr_expire;

    // Oscillator pulse accumulator for the pad under measurement
    logic [CNT_W-1:0] acc_next;
    touch_pulse_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst),
        .clr(st_q != ST_MEAS),
        .inc(st_q == ST_MEAS && osc_edge),
        .acc_next(acc_next)
    );

    // Threshold comparison and wake decision
    logic [NPADS-1:0] hit;
    logic wake;
    eval_mode_t mode;
    assign mode = '{cmp_above: cmp_above, single_set: single_set};
    touch_wake_eval #(.NPADS(NPADS), .CNT_W(CNT_W)) u_eval (
        .counts(cnt_q), .thresholds(thresh), .work_set(work_set),
        .set1_mask(set1_mask), .set2_mask(set2_mask), .mode(mode),
        .hit(hit), .wake(wake)
    );

    // Lowest working pad, and lowest working pad above the current one
    logic first_found, next_found;
    logic [IDX_W-1:0] first_idx, next_idx;
    always_comb begin
        first_found = 1'b0; first_idx = '0;
        next_found  = 1'b0; next_idx  = '0;
        for (int i = NPADS - 1; i >= 0; i--) begin
            if (work_set[i]) begin
                first_found = 1'b1; first_idx = IDX_W'(i);
            end
            if (work_set[i] && i > int'(cur_q)) begin
                next_found = 1'b1; next_idx = IDX_W'(i);
            end
        end
    end

    logic settle_end, meas_end;
    assign settle_end = phase_done(32'(ph_q), 32'(xpd_wait));
    assign meas_end   = phase_done(32'(ph_q), 32'(meas_window));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cur_q     <= '0;
            ph_q      <= '0;
            cnt_q     <= '0;
            touched_q <= '0;
            done_q    <= 1'b0;
            wake_q    <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            if (clr_touched) touched_q <= '0;
            case (st_q)
                ST_IDLE: if (launch) begin
                    done_q <= 1'b0;
                    ph_q   <= '0;
                    cur_q  <= first_idx;
                    st_q   <= first_found ? ST_SETTLE : ST_FINISH;
                end
                ST_SETTLE: begin
                    if (settle_end) begin
                        st_q <= ST_MEAS;
                        ph_q <= '0;
                    end else ph_q <= ph_q + 1'b1;
                end
                ST_MEAS: begin
                    if (meas_end) begin
                        cnt_q[cur_q] <= acc_next;
                        ph_q <= '0;
                        if (next_found) begin
                            cur_q <= next_idx;
                            st_q  <= ST_SETTLE;
                        end else st_q <= ST_FINISH;
                    end else ph_q <= ph_q + 1'b1;
                end
                default: begin
                    touched_q <= hit;
                    done_q    <= 1'b1;
                    wake_q    <= wake;
                    st_q      <= ST_IDLE;
                end
            endcase
        end
    end

    assign pad_sel     = cur_q;
    assign touch_xpd   = fsm_en ? (st_q == ST_SETTLE || st_q == ST_MEAS) : reg_xpd;
    assign touch_start = fsm_en ? (st_q == ST_MEAS) : reg_start;
    assign meas_count  = cnt_q;
    assign touched     = touched_q;
    assign scan_done   = done_q;
    assign wake_irq    = wake_q;

    p_start_needs_xpd_r5: assert property (@(posedge clk) disable iff (rst)
        (fsm_en && touch_start) |-> touch_xpd);
    p_sw_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !cfg_force_sw && !tmr_expire) |=> (st_q == ST_IDLE));
    p_ascending_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE && $past(st_q) == ST_MEAS) |-> (cur_q > $past(cur_q)));
    p_wake_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq);
    p_clear_r13: assert property (@(posedge clk) disable iff (rst)
        (clr_touched && st_q != ST_FINISH) |=> (touched == '0));
    p_done_at_end_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_done) |-> ($past(st_q) == ST_FINISH));

endmodule

// File: tb/touch_wake_ctrl_test.sv
module touch_osc_stub #(
    parameter int NPADS = 10,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             touch_start,
    input  logic [IDX_W-1:0] pad_sel,
    input  logic [NPADS*16-1:0] limits,
    output logic             osc_edge
);
    logic [15:0] run_q = '0;
    always_ff @(posedge clk) run_q <= touch_start ? run_q + 16'd1 : 16'd0;
    assign osc_edge = touch_start && (run_q < limits[16*int'(pad_sel) +: 16]);
endmodule

module touch_wake_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 10;
    localparam int WAITV = 3;
    localparam int WINV = 40;

    logic clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst, cfg_force_sw, sw_start, single_set, cmp_above, fsm_en, reg_xpd, reg_start, clr_touched;
    logic [15:0] sleep_cycles, meas_window;
    logic [7:0] xpd_wait;
    logic [NP-1:0] work_set, set1_mask, set2_mask, touched;
    logic [NP*16-1:0] thresh, meas_count, limits;
    logic osc_edge, touch_xpd, touch_start, scan_done, wake_irq;
    logic [3:0] pad_sel;

    touch_wake_ctrl uut (
        .clk(clk), .rst(rst), .cfg_force_sw(cfg_force_sw), .sw_start(sw_start),
        .sleep_cycles(sleep_cycles), .xpd_wait(xpd_wait), .meas_window(meas_window),
        .work_set(work_set), .set1_mask(set1_mask), .set2_mask(set2_mask),
        .single_set(single_set), .cmp_above(cmp_above), .thresh(thresh),
        .fsm_en(fsm_en), .reg_xpd(reg_xpd), .reg_start(reg_start),
        .clr_touched(clr_touched), .osc_edge(osc_edge), .pad_sel(pad_sel),
        .touch_xpd(touch_xpd), .touch_start(touch_start), .meas_count(meas_count),
        .touched(touched), .scan_done(scan_done), .wake_irq(wake_irq)
    );

    touch_osc_stub #(.NPADS(NP), .IDX_W(4)) u_osc (
        .clk(clk), .touch_start(touch_start), .pad_sel(pad_sel),
        .limits(limits), .osc_edge(osc_edge)
    );

    int errors = 0, checks = 0;
    int lim_a [NP] = '{10, 60, 25, 0, 7, 50, 3, 0, 0, 0};
    int thr_a [NP] = '{5, 100, 25, 0, 0, 39, 0, 0, 0, 0};

    // Negedge monitor of the pad controls
    int cyc = 0, xpd_hi = 0, start_hi = 0, xpd_rises = 0, wakes = 0, nseq = 0;
    int seq [16];
    int rise_t [8];
    logic prev_xpd = 0, prev_start = 0;
    always @(negedge clk) begin
        cyc++;
        if (touch_xpd) xpd_hi++;
        if (touch_start) start_hi++;
        if (wake_irq) wakes++;
        if (touch_start && !prev_start && nseq < 16) begin seq[nseq] = int'(pad_sel); nseq++; end
        if (touch_xpd && !prev_xpd) begin
            if (xpd_rises < 8) rise_t[xpd_rises] = cyc;
            xpd_rises++;
        end
        prev_xpd = touch_xpd;
        prev_start = touch_start;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        xpd_hi = 0; start_hi = 0; wakes = 0; nseq = 0; xpd_rises = 0;
    endtask

    task automatic apply_tables();
        for (int i = 0; i < NP; i++) begin
            thresh[16*i +: 16] = 16'(thr_a[i]);
            limits[16*i +: 16] = 16'(lim_a[i]);
        end
    endtask

    function automatic int exp_count(input int p);
        return (lim_a[p] < WINV) ? lim_a[p] : WINV;
    endfunction

    function automatic logic [NP-1:0] exp_touched(input logic above);
        logic [NP-1:0] t = '0;
        for (int i = 0; i < NP; i++)
            if (work_set[i]) t[i] = above ? (exp_count(i) > thr_a[i]) : (exp_count(i) < thr_a[i]);
        return t;
    endfunction

    task automatic sw_scan();
        @(negedge clk); cfg_force_sw = 1; sw_start = 1;
        @(negedge clk); sw_start = 0;
        for (int k = 0; k < 2000 && !scan_done; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        check("R1 touched", touched, 0);
        check("R1 done", scan_done, 0);
        check("R1 wake", wake_irq, 0);
        check("R1 xpd/start", {touch_xpd, touch_start}, 0);
        check("R1 counts", meas_count == '0, 1);
    endtask

    task automatic t_sw_scan_above();
        clear_mon();
        cmp_above = 1; work_set = 10'b10_0010_0101;
        @(negedge clk); cfg_force_sw = 1; sw_start = 1;
        @(negedge clk); sw_start = 0;
        check("R2 xpd after sw_start", touch_xpd, 1);
        for (int k = 0; k < 2000 && !scan_done; k++) @(negedge clk);
        check("R12 done set", scan_done, 1);
        check("R6 pad count", nseq, 4);
        check("R6 order 0", seq[0], 0); check("R6 order 1", seq[1], 2);
        check("R6 order 2", seq[2], 5); check("R6 order 3", seq[3], 9);
        check("R5 start cycles", start_hi, 4 * WINV);
        check("R5 xpd cycles", xpd_hi, 4 * (WAITV + WINV));
        for (int i = 0; i < NP; i++)
            check($sformatf("R7 count pad %0d", i), meas_count[16*i +: 16],
                  work_set[i] ? exp_count(i) : 0);
        check("R8 touched above", touched, exp_touched(1));
    endtask

    task automatic t_below();
        cmp_above = 0;
        sw_scan();
        check("R9 touched below", touched, exp_touched(0));
        check("R12 pad1 masked", touched[1], 0);
    endtask

    task automatic t_wake();
        cmp_above = 1;  // touched = pads 0 and 5
        single_set = 1; set1_mask = 10'b00_0000_0100; set2_mask = '1;
        clear_mon(); sw_scan(); repeat (2) @(negedge clk);
        check("R10 set1 untouched", wakes, 0);
        single_set = 0; set1_mask = 10'b00_0000_0001; set2_mask = 10'b00_0000_0100;
        clear_mon(); sw_scan(); repeat (2) @(negedge clk);
        check("R11 only set1", wakes, 0);
        set2_mask = 10'b00_0010_0000;
        clear_mon(); sw_scan(); repeat (2) @(negedge clk);
        check("R11 both sets", wakes, 1);
        single_set = 1; set2_mask = '0;
        clear_mon(); sw_scan(); repeat (2) @(negedge clk);
        check("R10 single set", wakes, 1);
    endtask

    task automatic t_clear();
        check("R13 touched before clear", touched != 0, 1);
        @(negedge clk); clr_touched = 1;
        @(negedge clk); clr_touched = 0;
        check("R13 cleared", touched, 0);
        check("R13 done kept", scan_done, 1);
    endtask

    task automatic t_manual();
        fsm_en = 0; reg_xpd = 1; reg_start = 0;
        @(negedge clk);
        check("R14 xpd follows", touch_xpd, 1);
        check("R14 start follows", touch_start, 0);
        reg_xpd = 0;
        @(negedge clk); cfg_force_sw = 1; sw_start = 1;
        @(negedge clk); sw_start = 0;
        repeat (5) @(negedge clk);
        check("R14 override during scan", {touch_xpd, touch_start}, 0);
        for (int k = 0; k < 2000 && !scan_done; k++) @(negedge clk);
        fsm_en = 1;
    endtask

    task automatic t_sw_ignored();
        sleep_cycles = 16'hFFFF;
        @(negedge clk); cfg_force_sw = 0;
        clear_mon();
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
        repeat (20) @(negedge clk);
        check("R3 no launch", xpd_rises, 0);
        check("R3 xpd low", touch_xpd, 0);
    endtask

    task automatic t_timer();
        work_set = 10'b00_0000_1000; sleep_cycles = 16'd30;
        clear_mon();
        for (int k = 0; k < 2000 && xpd_rises < 3; k++) @(negedge clk);
        check("R4 timer period", rise_t[2] - rise_t[1], WAITV + WINV + 1 + 30);
        @(negedge clk); cfg_force_sw = 1;
        for (int k = 0; k < 500 && !scan_done; k++) @(negedge clk);
    endtask

    logic finished = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_force_sw = 1; sw_start = 0; single_set = 1; cmp_above = 1;
        fsm_en = 1; reg_xpd = 0; reg_start = 0; clr_touched = 0;
        sleep_cycles = 16'h100; xpd_wait = 8'(WAITV); meas_window = 16'(WINV);
        work_set = '1; set1_mask = '1; set2_mask = '1;
        thresh = '0; limits = '0;
        apply_tables();
        t_reset();
        t_sw_scan_above();
        t_below();
        t_wake();
        t_clear();
        t_manual();
        t_sw_ignored();
        t_timer();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule